// File: doc/BRIEF.md
# Flow-Through Burst Memory

A synchronous single-port memory with four byte lanes per word and a parameterised number of words. Two address strobes can open an access: one meant for a processor and one for a cache controller. Both are active low, and the processor strobe wins when both are asserted. Every control and address input is registered on the rising clock edge. The registered address then reads the storage combinationally, so read data is valid in the cycle that follows the sampling edge, with no extra pipeline stage.

The two low address bits act as a burst counter. Once a burst has started, later cycles with no strobe step that counter when the advance input is low, and hold it when the advance input is high. After four steps the counter wraps back to the starting word. Three chip enables, two active low and one active high, gate each start cycle. A deselected start closes the burst and turns the outputs off.

The output enable of a shared bus is modelled by a valid flag. When the flag is low, the read data reads as zero. The flag falls on any write cycle and rises again on the next read access.

Top module: `fts_burst_ram`

## Requirements
- R1: While reset is low, and after it is released, `rvalid` is 0, `rdata` is 0 and no burst is open.
- R2: A start cycle is a cycle with either strobe low while the chip is selected (`en_a_n`=0, `en_b`=1, `en_c_n`=0). It captures `addr`, and when it is a read, the word at `addr` appears on `rdata` with `rvalid`=1 in the cycle after that edge.
- R3: When `pstb_n` is low, `cstb_n` and every write input are ignored, so the start cycle is always a read.
- R4: A start by `cstb_n` alone, with a write requested, stores `wdata` at `addr`, and `rvalid` is 0 in the next cycle.
- R5: On a cycle with no strobe inside an open burst, `adv_n`=0 adds one, modulo 4, to address bits [1:0]. The upper bits stay unchanged, so four advances return to the starting word.
- R6: On a cycle with no strobe inside an open burst, `adv_n`=1 keeps the address unchanged.
- R7: `gwr_n`=0 writes all four lanes, whatever `bwr_n` and `lane_n` say.
- R8: With `gwr_n`=1 and `bwr_n`=0, each `lane_n[i]`=0 writes byte bits [8i+7:8i] only. If `bwr_n`=1, or if `lane_n` is all ones, the cycle is a read.
- R9: A strobe cycle with the chip deselected (`en_a_n`=1, `en_b`=0 or `en_c_n`=1) drives `rvalid` to 0 and closes the burst. Later cycles with no strobe then neither read nor write.
- R10: Cycles with no strobe and no open burst leave `rvalid` unchanged. After a write, the output stays off until a read access.
- R11: A strobe inside an open burst restarts the burst at the new address and takes priority over `adv_n`.
- R12: `addr` is ignored on cycles with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address |
| pstb_n | input | 1 | Processor address strobe, active low, higher priority |
| cstb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| en_a_n | input | 1 | Chip enable, active low |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| gwr_n | input | 1 | Write all lanes, active low |
| bwr_n | input | 1 | Byte-write qualifier, active low |
| lane_n | input | LANES | Per-lane write selects, active low |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Flow-through read data, zero while off |
| rvalid | output | 1 | Output-enable flag |

## Verification
One table of cycles fills a burst through the controller strobe and then walks it back. The rows separate advance from hold and show the wrap to the starting word. They also show that `addr` changing mid-burst has no effect. Later rows give the processor strobe, the controller strobe and write inputs all at once, which separates strobe priority from write decoding. Two lane patterns and an all-ones pattern on `lane_n` separate masked byte writes from reads. The directed tests deselect through each enable in turn and then check that later cycles with no strobe leave storage untouched.

// File: rtl/fbr_pkg.sv
package fbr_pkg;

   // Kind of access decoded for one clock edge
   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2,
      ACC_DESEL = 2'd3
   } acc_e;

   // Width of the wrapping burst counter (four beats)
   localparam int BURST_BITS = 2;

endpackage

// File: rtl/fbr_decode.sv
module fbr_decode
   import fbr_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic             pstb_n,
   input  logic             cstb_n,
   input  logic             adv_n,
   input  logic             en_a_n,
   input  logic             en_b,
   input  logic             en_c_n,
   input  logic             gwr_n,
   input  logic             bwr_n,
   input  logic [LANES-1:0] lane_n,
   input  logic             burst_on,
   output acc_e             acc,
   output logic             load,
   output logic             step,
   output logic [LANES-1:0] wr_mask
);

   logic             chip_sel;
   logic             strobe;
   logic [LANES-1:0] lane_req;

   assign chip_sel = !en_a_n && en_b && !en_c_n;
   assign strobe   = !pstb_n || !cstb_n;

   // Global write overrides the per-lane controls
   always_comb begin
      if (!gwr_n)      lane_req = '1;
      else if (!bwr_n) lane_req = ~lane_n;
      else             lane_req = '0;
   end

   always_comb begin
      acc     = ACC_NONE;
      load    = 1'b0;
      step    = 1'b0;
      wr_mask = '0;
      if (strobe) begin
         if (!chip_sel) begin
            acc = ACC_DESEL;
         end else begin
            load = 1'b1;
            if (!pstb_n) begin
               // processor start: write inputs masked, always a read
               acc = ACC_READ;
            end else if (|lane_req) begin
               acc     = ACC_WRITE;
               wr_mask = lane_req;
            end else begin
               acc = ACC_READ;
            end
         end
      end else if (burst_on) begin
         step = !adv_n;
         if (|lane_req) begin
            acc     = ACC_WRITE;
            wr_mask = lane_req;
         end else begin
            acc = ACC_READ;
         end
      end
   end

endmodule

// File: rtl/fbr_burst_ctr.sv
module fbr_burst_ctr
   import fbr_pkg::*;
#(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic          kill,
   input  logic [AW-1:0] addr_in,
   output logic [AW-1:0] cur_addr,
   output logic [AW-1:0] nxt_addr,
   output logic          active
);

   localparam int HI_W = AW - BURST_BITS;

   logic [BURST_BITS-1:0] cnt_q;
   logic [BURST_BITS-1:0] cnt_d;
   logic [HI_W-1:0]       base_q;
   logic [HI_W-1:0]       base_d;

   always_comb begin
      if (load) begin
         cnt_d  = addr_in[BURST_BITS-1:0];
         base_d = addr_in[AW-1:BURST_BITS];
      end else begin
         cnt_d  = cnt_q + BURST_BITS'(step);
         base_d = base_q;
      end
   end

   assign nxt_addr = {base_d, cnt_d};
   assign cur_addr = {base_q, cnt_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         base_q <= '0;
         active <= 1'b0;
      end else begin
         cnt_q  <= cnt_d;
         base_q <= base_d;
         if (load)      active <= 1'b1;
         else if (kill) active <= 1'b0;
      end
   end

endmodule

// File: rtl/fbr_mem.sv
module fbr_mem #(
   parameter int AW     = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic [LANES-1:0]        wr_mask,
   input  logic [AW-1:0]           waddr,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic [AW-1:0]           raddr,
   output logic [LANES*LANE_W-1:0] rdata
);

   localparam int DEPTH = 1 << AW;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] store [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_mask[g]) store[waddr] <= wdata[g*LANE_W +: LANE_W];
      end

      assign rdata[g*LANE_W +: LANE_W] = store[raddr];
   end

endmodule

// File: rtl/fts_burst_ram.sv
module fts_burst_ram
   import fbr_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    pstb_n,
   input  logic                    cstb_n,
   input  logic                    adv_n,
   input  logic                    en_a_n,
   input  logic                    en_b,
   input  logic                    en_c_n,
   input  logic                    gwr_n,
   input  logic                    bwr_n,
   input  logic [LANES-1:0]        lane_n,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata,
   output logic                    rvalid
);

   localparam int DW = LANES * LANE_W;

   if (ADDR_W <= BURST_BITS) begin : g_bad_aw
      $error("ADDR_W must exceed the burst counter width");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("LANES and LANE_W must be positive");
   end

   acc_e              acc;
   logic              load;
   logic              step;
   logic [LANES-1:0]  wr_mask;
   logic              burst_on;
   logic [ADDR_W-1:0] cur_addr;
   logic [ADDR_W-1:0] nxt_addr;
   logic [DW-1:0]     word;

   fbr_decode #(.LANES(LANES)) u_dec (
      .pstb_n  (pstb_n),
      .cstb_n  (cstb_n),
      .adv_n   (adv_n),
      .en_a_n  (en_a_n),
      .en_b    (en_b),
      .en_c_n  (en_c_n),
      .gwr_n   (gwr_n),
      .bwr_n   (bwr_n),
      .lane_n  (lane_n),
      .burst_on(burst_on),
      .acc     (acc),
      .load    (load),
      .step    (step),
      .wr_mask (wr_mask)
   );

   fbr_burst_ctr #(.AW(ADDR_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .step    (step),
      .kill    (acc == ACC_DESEL),
      .addr_in (addr),
      .cur_addr(cur_addr),
      .nxt_addr(nxt_addr),
      .active  (burst_on)
   );

   fbr_mem #(.AW(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
      .clk    (clk),
      .wr_mask(wr_mask),
      .waddr  (nxt_addr),
      .wdata  (wdata),
      .raddr  (cur_addr),
      .rdata  (word)
   );

   // Output-enable flag: set by reads, cleared by writes and deselects
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rvalid <= 1'b0;
      end else begin
         unique case (acc)
            ACC_READ:  rvalid <= 1'b1;
            ACC_WRITE: rvalid <= 1'b0;
            ACC_DESEL: rvalid <= 1'b0;
            default:   rvalid <= rvalid;
         endcase
      end
   end

   assign rdata = rvalid ? word : '0;

endmodule

// File: rtl/fbr_checker.sv
module fbr_checker #(
   parameter int AW    = 8,
   parameter int LANES = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [AW-1:0]    addr,
   input logic             pstb_n,
   input logic             cstb_n,
   input logic             adv_n,
   input logic             en_a_n,
   input logic             en_b,
   input logic             en_c_n,
   input logic             gwr_n,
   input logic             bwr_n,
   input logic [LANES-1:0] lane_n,
   input logic             rvalid,
   input logic [AW-1:0]    cur_addr,
   input logic             active
);

   logic sel;
   logic strobe;
   logic wr_ask;

   assign sel    = !en_a_n && en_b && !en_c_n;
   assign strobe = !pstb_n || !cstb_n;
   assign wr_ask = !gwr_n || (!bwr_n && (lane_n != '1));

   p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && sel) |=> (active && cur_addr == $past(addr)));

   p_pstrobe_reads_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!pstb_n && sel) |=> rvalid);

   p_write_blanks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pstb_n && !cstb_n && sel && wr_ask) |=> !rvalid);

   p_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe && active && !adv_n) |=>
         (cur_addr[1:0] == 2'($past(cur_addr[1:0]) + 2'd1)
          && cur_addr[AW-1:2] == $past(cur_addr[AW-1:2])));

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe && active && adv_n) |=> $stable(cur_addr));

   p_deselect_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && !sel) |=> (!rvalid && !active));

   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe && !active) |=> $stable(rvalid));

endmodule

bind fts_burst_ram fbr_checker #(.AW(ADDR_W), .LANES(LANES)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .addr    (addr),
   .pstb_n  (pstb_n),
   .cstb_n  (cstb_n),
   .adv_n   (adv_n),
   .en_a_n  (en_a_n),
   .en_b    (en_b),
   .en_c_n  (en_c_n),
   .gwr_n   (gwr_n),
   .bwr_n   (bwr_n),
   .lane_n  (lane_n),
   .rvalid  (rvalid),
   .cur_addr(cur_addr),
   .active  (burst_on)
);

// File: tb/fts_burst_ram_test.sv
module fts_burst_ram_test;

   localparam int PERIOD = 10;

   // {en_a_n, en_b, en_c_n}
   localparam logic [2:0] SEL_OK = 3'b010;

   typedef struct packed {
      logic        ps_n;
      logic        cs_n;
      logic        adv_n;
      logic [2:0]  sel;
      logic        gw_n;
      logic        bw_n;
      logic [3:0]  ln;
      logic [7:0]  a;
      logic [31:0] wd;
      logic        ev;
      logic [31:0] ed;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VECS [NV] = '{
      // R4: controller start, global write at 0x10
      '{1'b1,1'b0,1'b1,SEL_OK,1'b0,1'b1,4'hF,8'h10,32'hA0A0A010,1'b0,32'h0,4'd4},
      // R5, R12: advance and write 0x11, addr input ignored
      '{1'b1,1'b1,1'b0,SEL_OK,1'b0,1'b1,4'hF,8'hFF,32'h11111111,1'b0,32'h0,4'd5},
      // R5: write 0x12
      '{1'b1,1'b1,1'b0,SEL_OK,1'b0,1'b1,4'hF,8'h00,32'h22222222,1'b0,32'h0,4'd5},
      // R5: write 0x13
      '{1'b1,1'b1,1'b0,SEL_OK,1'b0,1'b1,4'hF,8'h00,32'h33333333,1'b0,32'h0,4'd5},
      // R6: suspended, read 0x13
      '{1'b1,1'b1,1'b1,SEL_OK,1'b1,1'b1,4'hF,8'h55,32'h0,1'b1,32'h33333333,4'd6},
      // R5: wrap to 0x10
      '{1'b1,1'b1,1'b0,SEL_OK,1'b1,1'b1,4'hF,8'h00,32'h0,1'b1,32'hA0A0A010,4'd5},
      // R3: both strobes plus writes, read 0x12
      '{1'b0,1'b0,1'b1,SEL_OK,1'b0,1'b0,4'h0,8'h12,32'hDEADBEEF,1'b1,32'h22222222,4'd3},
      // R8: lanes 0 and 2 written
      '{1'b1,1'b1,1'b1,SEL_OK,1'b1,1'b0,4'hA,8'h00,32'hAABBCCDD,1'b0,32'h0,4'd8},
      // R8: read back merged word
      '{1'b1,1'b1,1'b1,SEL_OK,1'b1,1'b1,4'hF,8'h00,32'h0,1'b1,32'h22BB22DD,4'd8},
      // R8: byte qualifier low but no lane, a read
      '{1'b1,1'b1,1'b1,SEL_OK,1'b1,1'b0,4'hF,8'h00,32'h12345678,1'b1,32'h22BB22DD,4'd8},
      // R7: global write overrides qualifier high
      '{1'b1,1'b1,1'b1,SEL_OK,1'b0,1'b1,4'hF,8'h00,32'h01020304,1'b0,32'h0,4'd7},
      // R9: deselect through en_b
      '{1'b1,1'b0,1'b1,3'b000,1'b1,1'b1,4'hF,8'h40,32'h0,1'b0,32'h0,4'd9},
      // R10: idle, write inputs have no effect
      '{1'b1,1'b1,1'b0,SEL_OK,1'b0,1'b0,4'h0,8'h00,32'hFFFFFFFF,1'b0,32'h0,4'd10},
      // R2: controller read start at 0x12
      '{1'b1,1'b0,1'b1,SEL_OK,1'b1,1'b1,4'hF,8'h12,32'h0,1'b1,32'h01020304,4'd2},
      // R5: advance to 0x13
      '{1'b1,1'b1,1'b0,SEL_OK,1'b1,1'b1,4'hF,8'h00,32'h0,1'b1,32'h33333333,4'd5},
      // R11: restart at 0x11 while advance low
      '{1'b1,1'b0,1'b0,SEL_OK,1'b1,1'b1,4'hF,8'h11,32'h0,1'b1,32'h11111111,4'd11},
      // R5: advance to 0x12
      '{1'b1,1'b1,1'b0,SEL_OK,1'b1,1'b1,4'hF,8'h00,32'h0,1'b1,32'h01020304,4'd5}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr = '0;
   logic        pstb_n = 1'b1;
   logic        cstb_n = 1'b1;
   logic        adv_n = 1'b1;
   logic        en_a_n = 1'b0;
   logic        en_b = 1'b1;
   logic        en_c_n = 1'b0;
   logic        gwr_n = 1'b1;
   logic        bwr_n = 1'b1;
   logic [3:0]  lane_n = 4'hF;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        rvalid;

   int checks = 0;
   int fails  = 0;

   always #(PERIOD/2) clk = ~clk;

   fts_burst_ram uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .pstb_n(pstb_n), .cstb_n(cstb_n),
      .adv_n(adv_n), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
      .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_n(lane_n), .wdata(wdata),
      .rdata(rdata), .rvalid(rvalid)
   );

   task automatic check(input logic ev, input logic [31:0] ed, input string tag);
      checks++;
      if (rvalid !== ev || rdata !== ed) begin
         fails++;
         $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                  tag, rvalid, rdata, ev, ed);
      end
   endtask

   // Drive one cycle at a falling edge; outputs settle by the next falling edge
   task automatic cyc(input vec_t v);
      pstb_n = v.ps_n;  cstb_n = v.cs_n;  adv_n = v.adv_n;
      {en_a_n, en_b, en_c_n} = v.sel;
      gwr_n = v.gw_n;   bwr_n = v.bw_n;   lane_n = v.ln;
      addr = v.a;       wdata = v.wd;
      @(negedge clk);
   endtask

   function automatic vec_t mk(input logic ps, input logic cs, input logic adv,
                               input logic [2:0] s, input logic gw, input logic [7:0] a,
                               input logic [31:0] wd);
      vec_t v;
      v = '0;
      v.ps_n = ps; v.cs_n = cs; v.adv_n = adv; v.sel = s;
      v.gw_n = gw; v.bw_n = 1'b1; v.ln = 4'hF; v.a = a; v.wd = wd;
      return v;
   endfunction

   initial begin
      #(PERIOD * 20000);
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(1'b0, 32'h0, "R1 during reset");
      rst_n = 1'b1;
      @(negedge clk);
      check(1'b0, 32'h0, "R1 after release");

      for (int i = 0; i < NV; i++) begin
         cyc(VECS[i]);
         check(VECS[i].ev, VECS[i].ed, $sformatf("R%0d row %0d", VECS[i].rq, i));
      end

      // R1: reset in the middle of an active read
      rst_n = 1'b0;
      @(negedge clk);
      check(1'b0, 32'h0, "R1 mid-run reset");
      rst_n = 1'b1;
      @(negedge clk);

      // R9: deselect through en_a_n ends the burst
      cyc(mk(1'b1, 1'b0, 1'b1, SEL_OK, 1'b1, 8'h10, 32'h0));
      check(1'b1, 32'hA0A0A010, "R2 read start 0x10");
      cyc(mk(1'b1, 1'b0, 1'b1, 3'b110, 1'b1, 8'h11, 32'h0));
      check(1'b0, 32'h0, "R9 deselect en_a_n");
      cyc(mk(1'b1, 1'b1, 1'b0, SEL_OK, 1'b1, 8'h00, 32'h0));
      check(1'b0, 32'h0, "R9 no read after deselect");

      // R9: deselect through en_c_n with the processor strobe
      cyc(mk(1'b0, 1'b1, 1'b1, SEL_OK, 1'b1, 8'h13, 32'h0));
      check(1'b1, 32'h33333333, "R2 processor read 0x13");
      cyc(mk(1'b0, 1'b1, 1'b1, 3'b011, 1'b1, 8'h13, 32'h0));
      check(1'b0, 32'h0, "R9 deselect en_c_n");

      // R4 then R10: write blanks output, next read restores it
      cyc(mk(1'b1, 1'b0, 1'b1, SEL_OK, 1'b0, 8'h20, 32'hCAFEF00D));
      check(1'b0, 32'h0, "R4 write start 0x20");
      cyc(mk(1'b0, 1'b1, 1'b1, SEL_OK, 1'b1, 8'h20, 32'h0));
      check(1'b1, 32'hCAFEF00D, "R10 read after write");

      // R12: address changes during suspended cycles are ignored
      cyc(mk(1'b1, 1'b1, 1'b1, SEL_OK, 1'b1, 8'h13, 32'h0));
      check(1'b1, 32'hCAFEF00D, "R12 addr ignored");

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule